// File: doc/BRIEF.md
# Resynchronizable Output Clock Divider

This block derives a half-rate data clock from a fast input clock. Several copies of it can share one input clock and one resync request line. A pulse on that line re-aligns every copy, so their data clocks run in the same phase no matter how each copy came out of reset.

The request is asynchronous. It passes through a two-flop synchronizer. Once the synchronized request has fallen, a fixed count of input-clock edges follows, and the divider then restarts low on a single deterministic aligning edge. The count depends on the phase-mode select. In demux mode the data clock is parked high while the request is held and stays high until that aligning edge. In non-demux mode the clock keeps running. The mode selects are captured only while the synchronized request is high, so a change made during the countdown does not disturb it. The whole feature is gated by an enable bit that is low after reset.

Top module: `oclk_resync`

## Requirements
- R1: After reset the data clock equals the INIT_LEVEL parameter. With no request in progress, it inverts on every input-clock rising edge, which is divide-by-two.
- R2: While resync_en is 0, resync_req has no effect: the data clock keeps inverting on every edge, and instances that started with different levels stay opposite.
- R3: With demux_sel = 1, the data clock is 1 from the third input-clock rising edge after the request rises. It stays 1 while the request is held, and it stays 1 after release up to, but not including, the aligning edge.
- R4: With demux_sel = 0, the data clock keeps inverting on every edge while the request is held and while the post-release countdown runs.
- R5: With phase90_sel = 1, call E0 the first rising edge at which resync_req reads 0. The aligning edge is E4, and the data clock is 0 right after it.
- R6: With phase90_sel = 0, the aligning edge is E5, and the data clock is 0 right after it.
- R7: After the aligning edge, the data clock inverts on every edge. All instances that share the input clock, the request and the mode settings are then identical on every cycle.
- R8: demux_sel and phase90_sel are sampled only while the synchronized request is high. That sampling ends at E1. Changes applied after E1 alter neither the hold level nor the aligning edge of the countdown in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| resync_req | input | 1 | Asynchronous re-align request, active high |
| resync_en | input | 1 | Enables the re-align feature |
| demux_sel | input | 1 | 1: park the clock high during a request; 0: keep it running |
| phase90_sel | input | 1 | 1: aligning edge at E4; 0: at E5 |
| dclk_out | output | 1 | Half-rate data clock |

## Verification
Two instances are reset with opposite start levels, so any alignment fault shows up as a difference between them. The bench checks the exact aligning edge in both phase modes. If the delay were off by one edge, in demux mode the low level would appear one cycle early or late, and in non-demux mode the two clocks would agree one cycle too soon or stay opposite. A request made while the feature is disabled must leave the opposite phases intact; a design that did not gate the request would merge them. The selects are flipped right after E1, so a design that kept sampling them would show the wrong delay or drop the high hold level early.

// File: rtl/oclk_resync.sv
module oclk_resync #(
  parameter logic INIT_LEVEL = 1'b0,
  parameter int   DLY_90     = 4,
  parameter int   DLY_0      = 5
) (
  input  logic clk_in,
  input  logic rst_n,
  input  logic resync_req,
  input  logic resync_en,
  input  logic demux_sel,
  input  logic phase90_sel,
  output logic dclk_out
);
  localparam int DMAX = (DLY_90 > DLY_0) ? DLY_90 : DLY_0;
  localparam int CW   = $clog2(DMAX + 1);
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] LD90 = CW'(DLY_90 - 2);
  localparam logic [CW-1:0] LD0  = CW'(DLY_0 - 2);

  logic          req_m, req_s, armed, dmx_lat, ph_lat, dclk_q;
  logic [CW-1:0] cnt;

  wire hold_now  = resync_en & req_s & demux_sel;
  wire hold_wait = dmx_lat & (armed | (cnt > ONE));
  wire align     = (cnt == ONE);

  always_ff @(posedge clk_in) begin
    if (!rst_n) begin
      req_m   <= 1'b0;
      req_s   <= 1'b0;
      armed   <= 1'b0;
      cnt     <= '0;
      dmx_lat <= 1'b0;
      ph_lat  <= 1'b0;
    end else begin
      req_m <= resync_req;
      req_s <= req_m;
      if (resync_en && req_s) begin
        armed   <= 1'b1;
        cnt     <= '0;
        dmx_lat <= demux_sel;
        ph_lat  <= phase90_sel;
      end else if (armed && !req_s) begin
        armed <= 1'b0;
        cnt   <= ph_lat ? LD90 : LD0;
      end else if (cnt != '0) begin
        cnt <= cnt - ONE;
      end
    end
  end

  always_ff @(posedge clk_in) begin
    if (!rst_n)                     dclk_q <= INIT_LEVEL;
    else if (align)                 dclk_q <= 1'b0;
    else if (hold_now || hold_wait) dclk_q <= 1'b1;
    else                            dclk_q <= ~dclk_q;
  end

  assign dclk_out = dclk_q;
endmodule

// File: rtl/oclk_resync_chk.sv
module oclk_resync_chk #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          dmx_sel,
  input logic          req_s,
  input logic          armed,
  input logic [CW-1:0] cnt,
  input logic          dmx_lat,
  input logic          ph_lat,
  input logic          dclk
);
  a_r3_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (en && req_s && dmx_sel) |=> dclk);

  a_r3_wait_high: assert property (@(posedge clk) disable iff (!rst_n)
    (dmx_lat && armed) |=> dclk);

  a_r5_align_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(1)) |=> !dclk);

  a_r4_free_run: assert property (@(posedge clk) disable iff (!rst_n)
    (!dmx_sel && !dmx_lat && cnt != CW'(1)) |=> (dclk != $past(dclk)));

  a_r7_idle_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_s && !armed && cnt == '0) |=> (dclk != $past(dclk)));

  a_r8_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_s |=> ($stable(dmx_lat) && $stable(ph_lat)));
endmodule

bind oclk_resync oclk_resync_chk #(.CW(CW)) u_chk (
  .clk(clk_in), .rst_n(rst_n), .en(resync_en), .dmx_sel(demux_sel),
  .req_s(req_s), .armed(armed), .cnt(cnt), .dmx_lat(dmx_lat),
  .ph_lat(ph_lat), .dclk(dclk_q)
);

// File: tb/oclk_resync_tb_top.sv
module oclk_resync_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, en = 1'b0, dmx = 1'b0, ph = 1'b0;
  logic a, b;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  oclk_resync #(.INIT_LEVEL(1'b0)) dut_i (
    .clk_in(clk), .rst_n(rst_n), .resync_req(req), .resync_en(en),
    .demux_sel(dmx), .phase90_sel(ph), .dclk_out(a));
  oclk_resync #(.INIT_LEVEL(1'b1)) dut_b (
    .clk_in(clk), .rst_n(rst_n), .resync_req(req), .resync_en(en),
    .demux_sel(dmx), .phase90_sel(ph), .dclk_out(b));

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset level dut_i", a, 1'b0);
    check("R1 reset level dut_b", b, 1'b1);
  endtask

  task automatic t_idle();
    do_reset();
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      check("R1 idle divide dut_i", a, logic'(i[0]));
      check("R1 idle divide dut_b", b, ~logic'(i[0]));
    end
  endtask

  task automatic t_disabled();
    logic prev;
    do_reset();
    en = 1'b0; dmx = 1'b1; ph = 1'b1;
    prev = a;
    @(posedge clk); #1 req = 1'b1;
    for (int i = 0; i < 24; i++) begin
      if (i == 12) begin @(posedge clk); #1 req = 1'b0; end
      @(negedge clk);
      check("R2 disabled toggle", a != prev, 1'b1);
      check("R2 disabled phases kept", a != b, 1'b1);
      prev = a;
    end
  endtask

  task automatic t_align(input logic p90, input logic dm, input logic flip);
    logic prev;
    int d;
    string tg;
    d  = p90 ? 4 : 5;
    tg = flip ? "R8" : (p90 ? "R5" : "R6");
    do_reset();
    @(posedge clk); #1 en = 1'b1; dmx = dm; ph = p90; req = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    prev = a;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (dm) begin
        check("R3 held high dut_i", a, 1'b1);
        check("R3 held high dut_b", b, 1'b1);
      end else begin
        check("R4 running while held", a != prev, 1'b1);
        check("R4 phases untouched", a != b, 1'b1);
      end
      prev = a;
    end
    @(posedge clk); #1 req = 1'b0;
    for (int k = 0; k < d; k++) begin
      @(posedge clk);
      if (flip && k == 1) begin #1 dmx = ~dm; ph = ~p90; end
      @(negedge clk);
      if (dm) begin
        check({tg, " R3 high before align dut_i"}, a, 1'b1);
        check({tg, " R3 high before align dut_b"}, b, 1'b1);
      end else begin
        check({tg, " R4 still opposite before align"}, a != b, 1'b1);
      end
    end
    @(negedge clk);
    check({tg, " aligning edge dut_i"}, a, 1'b0);
    check({tg, " aligning edge dut_b"}, b, 1'b0);
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      check("R7 divide after align", a, logic'(i[0]));
      check("R7 instances match", b, a);
    end
    en = 1'b0;
  endtask

  initial begin
    t_idle();
    t_disabled();
    t_align(1'b1, 1'b0, 1'b0);
    t_align(1'b1, 1'b1, 1'b0);
    t_align(1'b0, 1'b1, 1'b0);
    t_align(1'b0, 1'b0, 1'b0);
    t_align(1'b1, 1'b1, 1'b1);
    t_align(1'b0, 1'b1, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_600_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule